// File: doc/BRIEF.md
# Dual Interval Timer with Reload Latches

The block provides two 16-bit down-counters behind a byte-wide register window. Software reaches them through a 4-bit register index, an 8-bit write bus, and write and read strobes. The read bus is combinational and follows the index. Each access has its own side effects, and the register being touched decides them. Some writes only stage a latch byte. One write stages the high byte and also loads the counter. Some reads clear a timer's interrupt flag. An interrupt controller can also clear either flag through a dedicated input.

Both counters move down by one on each cycle in which `cnt_tick` is high. Timer 1 has a 16-bit reload latch. When `t1_free_run` is high, timer 1 reloads from that latch each time it passes through zero. When it is low, timer 1 runs one-shot: it wraps to 0xFFFF and keeps counting. Timer 2 has only an 8-bit low latch and always runs one-shot.

Each timer has a two-state arming machine. `ST_ARMED` means the next pass through zero sets the flag. `ST_SPENT` means it will not. The transitions are:
- load: any state goes to `ST_ARMED`.
- expire: `ST_ARMED` goes to `ST_SPENT` on a pass through zero while in one-shot mode.
- hold: the state stays as it is on every other cycle. Timer 1 in free-run mode stays in `ST_ARMED` when it passes through zero.

Reset puts both machines in `ST_SPENT`.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters read 0xFFFF, the timer 1 latch reads 0x0000, both flags are 0 and both arming machines are in ST_SPENT.
- R2: A write to index 0x4 or 0x6 replaces the low byte of the timer 1 latch. It leaves the latch high byte, the timer 1 counter and the timer 1 flag unchanged.
- R3: A write to index 0x5 stores the byte as the timer 1 latch high byte and clears the timer 1 flag. On the next edge it loads the timer 1 counter with {written byte, latch low byte} and arms timer 1.
- R4: A write to index 0x7 stores the byte as the timer 1 latch high byte and clears the timer 1 flag. It does not change the counter.
- R5: Reading index 0x4 returns counter 1 bits 7:0 and clears the timer 1 flag. Reading index 0x5 returns bits 15:8 and leaves the flag unchanged.
- R6: Reading index 0x6 returns timer 1 latch bits 7:0, and reading index 0x7 returns bits 15:8.
- R7: A write to index 0x8 stores the 8-bit timer 2 latch. A write to index 0x9 loads counter 2 with {written byte, timer 2 latch} and arms timer 2, without changing the timer 2 flag.
- R8: Reading index 0x8 returns counter 2 bits 7:0 and clears the timer 2 flag. Reading index 0x9 returns bits 15:8.
- R9: A counter decrements by one on an edge where cnt_tick is 1 and it is not being loaded. It holds its value when cnt_tick is 0.
- R10: Timer 1 in one-shot mode (t1_free_run=0) goes from 0x0000 to 0xFFFF on a tick. Its flag is set only at the first pass through zero after a load.
- R11: Timer 1 in free-run mode (t1_free_run=1) loads its latch value on a tick at 0x0000. Its flag is set on every such pass.
- R12: Timer 2 goes from 0x0000 to 0xFFFF on a tick. Its flag is set only at the first pass through zero after a load.
- R13: t1_flag_clr and t2_flag_clr clear their flags. A flag set and a flag clear on the same edge leave the flag at 1. A load by index 0x5 on a tick edge wins over the decrement and cancels the pass through zero.
- R14: Indices other than 0x4 to 0x9 read 0x00, and writes to them change no timer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_idx | input | 4 | Register index |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe; enables read side effects |
| rd_data | output | 8 | Read data for reg_idx, combinational |
| cnt_tick | input | 1 | Count enable for both counters |
| t1_free_run | input | 1 | 1 selects free-run mode for timer 1 |
| t1_flag_clr | input | 1 | Clears the timer 1 flag |
| t2_flag_clr | input | 1 | Clears the timer 2 flag |
| t1_flag | output | 1 | Timer 1 interrupt flag |
| t2_flag | output | 1 | Timer 2 interrupt flag |

## Verification
A flag set by a pass through zero can land on the same edge as a clear of that flag. The clear can come from the flag-clear input, from a read of the counter low byte, or from a write to index 0x7. The bench counts a timer down to 0x0000 and then pulses the clear on the tick that wraps it. The flag must still be 1, and the next clear alone must drop it. A second collision is a reload by index 0x5 on the edge where counter 1 would pass through zero. Here the load must win, and the flag must end cleared. Random access mixes with small reload values produce many more of these collisions, and each is judged against the bench model of the requirements.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IX_T1_CNT_LO = 4'h4;
    localparam logic [IDX_W-1:0] IX_T1_CNT_HI = 4'h5;
    localparam logic [IDX_W-1:0] IX_T1_LAT_LO = 4'h6;
    localparam logic [IDX_W-1:0] IX_T1_LAT_HI = 4'h7;
    localparam logic [IDX_W-1:0] IX_T2_CNT_LO = 4'h8;
    localparam logic [IDX_W-1:0] IX_T2_CNT_HI = 4'h9;

    typedef enum logic {
        ST_SPENT = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;
endpackage

// File: rtl/dit_timer1.sv
module dit_timer1
    import dit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                free_run,
    input  logic                wr_lat_lo,
    input  logic                wr_hi_load,
    input  logic                wr_hi_keep,
    input  logic                rd_cnt_lo,
    input  logic                flag_clr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic [2*BYTE_W-1:0] latch,
    output logic                flag
);
    localparam int CNT_W = 2 * BYTE_W;

    arm_state_e state_q, state_d;
    logic at_zero, underflow, clr_any;

    assign at_zero   = (cnt == '0);
    assign underflow = tick && at_zero && !wr_hi_load;
    assign clr_any   = wr_hi_load || wr_hi_keep || rd_cnt_lo || flag_clr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (wr_hi_load)                  state_d = ST_ARMED;
                else if (underflow && !free_run) state_d = ST_SPENT;
            end
            ST_SPENT: begin
                if (wr_hi_load) state_d = ST_ARMED;
            end
            default: state_d = ST_SPENT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SPENT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch <= '0;
            cnt   <= '1;
            flag  <= 1'b0;
        end else begin
            if (wr_lat_lo)
                latch[BYTE_W-1:0] <= wdata;
            if (wr_hi_load || wr_hi_keep)
                latch[CNT_W-1:BYTE_W] <= wdata;
            if (wr_hi_load)
                cnt <= {wdata, latch[BYTE_W-1:0]};
            else if (tick)
                cnt <= at_zero ? (free_run ? latch : '1) : cnt - CNT_W'(1);
            if (underflow && state_q == ST_ARMED)
                flag <= 1'b1;
            else if (clr_any)
                flag <= 1'b0;
        end
    end

    AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_load |=> cnt == {$past(wdata), $past(latch[BYTE_W-1:0])}); // R3
    AST_T1_LO_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lat_lo && !tick && !wr_hi_load) |=> $stable(cnt)); // R2
    AST_T1_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !wr_hi_load) |=> !$rose(flag)); // R10
    AST_T1_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && free_run && !wr_hi_load) |=> cnt == $past(latch)); // R11
endmodule

// File: rtl/dit_timer2.sv
module dit_timer2
    import dit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_lat,
    input  logic                wr_cnt_hi,
    input  logic                rd_cnt_lo,
    input  logic                flag_clr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic                flag
);
    localparam int CNT_W = 2 * BYTE_W;

    arm_state_e state_q, state_d;
    logic [BYTE_W-1:0] latch;
    logic underflow;

    assign underflow = tick && (cnt == '0) && !wr_cnt_hi;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (wr_cnt_hi)      state_d = ST_ARMED;
                else if (underflow) state_d = ST_SPENT;
            end
            ST_SPENT: begin
                if (wr_cnt_hi) state_d = ST_ARMED;
            end
            default: state_d = ST_SPENT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SPENT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch <= '0;
            cnt   <= '1;
            flag  <= 1'b0;
        end else begin
            if (wr_lat)
                latch <= wdata;
            if (wr_cnt_hi)
                cnt <= {wdata, latch};
            else if (tick)
                cnt <= cnt - CNT_W'(1);
            if (underflow && state_q == ST_ARMED)
                flag <= 1'b1;
            else if (rd_cnt_lo || flag_clr)
                flag <= 1'b0;
        end
    end

    AST_T2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi |=> cnt == {$past(wdata), $past(latch)}); // R7
    AST_T2_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt_lo && !(tick && cnt == '0)) |=> !flag); // R8
    AST_T2_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !wr_cnt_hi) |=> !$rose(flag)); // R12
endmodule

// File: rtl/dit_regif.sv
module dit_regif
    import dit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [2*BYTE_W-1:0] t1_cnt,
    input  logic [2*BYTE_W-1:0] t1_latch,
    input  logic [2*BYTE_W-1:0] t2_cnt,
    output logic                t1_wr_lat_lo,
    output logic                t1_wr_hi_load,
    output logic                t1_wr_hi_keep,
    output logic                t1_rd_cnt_lo,
    output logic                t2_wr_lat,
    output logic                t2_wr_cnt_hi,
    output logic                t2_rd_cnt_lo,
    output logic [BYTE_W-1:0]   rd_data
);
    localparam int CNT_W = 2 * BYTE_W;

    assign t1_wr_lat_lo  = wr_en && (reg_idx == IX_T1_CNT_LO || reg_idx == IX_T1_LAT_LO);
    assign t1_wr_hi_load = wr_en && (reg_idx == IX_T1_CNT_HI);
    assign t1_wr_hi_keep = wr_en && (reg_idx == IX_T1_LAT_HI);
    assign t1_rd_cnt_lo  = rd_en && (reg_idx == IX_T1_CNT_LO);
    assign t2_wr_lat     = wr_en && (reg_idx == IX_T2_CNT_LO);
    assign t2_wr_cnt_hi  = wr_en && (reg_idx == IX_T2_CNT_HI);
    assign t2_rd_cnt_lo  = rd_en && (reg_idx == IX_T2_CNT_LO);

    always_comb begin
        rd_data = '0;
        case (reg_idx)
            IX_T1_CNT_LO: rd_data = t1_cnt[BYTE_W-1:0];
            IX_T1_CNT_HI: rd_data = t1_cnt[CNT_W-1:BYTE_W];
            IX_T1_LAT_LO: rd_data = t1_latch[BYTE_W-1:0];
            IX_T1_LAT_HI: rd_data = t1_latch[CNT_W-1:BYTE_W];
            IX_T2_CNT_LO: rd_data = t2_cnt[BYTE_W-1:0];
            IX_T2_CNT_HI: rd_data = t2_cnt[CNT_W-1:BYTE_W];
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cnt_tick,
    input  logic              t1_free_run,
    input  logic              t1_flag_clr,
    input  logic              t2_flag_clr,
    output logic              t1_flag,
    output logic              t2_flag
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] t1_cnt, t1_latch, t2_cnt;
    logic t1_wr_lat_lo, t1_wr_hi_load, t1_wr_hi_keep, t1_rd_cnt_lo;
    logic t2_wr_lat, t2_wr_cnt_hi, t2_rd_cnt_lo;

    dit_regif #(.BYTE_W(BYTE_W)) u_regif (
        .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
        .t1_cnt(t1_cnt), .t1_latch(t1_latch), .t2_cnt(t2_cnt),
        .t1_wr_lat_lo(t1_wr_lat_lo), .t1_wr_hi_load(t1_wr_hi_load),
        .t1_wr_hi_keep(t1_wr_hi_keep), .t1_rd_cnt_lo(t1_rd_cnt_lo),
        .t2_wr_lat(t2_wr_lat), .t2_wr_cnt_hi(t2_wr_cnt_hi),
        .t2_rd_cnt_lo(t2_rd_cnt_lo), .rd_data(rd_data)
    );

    dit_timer1 #(.BYTE_W(BYTE_W)) u_t1 (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .free_run(t1_free_run),
        .wr_lat_lo(t1_wr_lat_lo), .wr_hi_load(t1_wr_hi_load),
        .wr_hi_keep(t1_wr_hi_keep), .rd_cnt_lo(t1_rd_cnt_lo),
        .flag_clr(t1_flag_clr), .wdata(wr_data),
        .cnt(t1_cnt), .latch(t1_latch), .flag(t1_flag)
    );

    dit_timer2 #(.BYTE_W(BYTE_W)) u_t2 (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
        .wr_lat(t2_wr_lat), .wr_cnt_hi(t2_wr_cnt_hi), .rd_cnt_lo(t2_rd_cnt_lo),
        .flag_clr(t2_flag_clr), .wdata(wr_data),
        .cnt(t2_cnt), .flag(t2_flag)
    );

    AST_CLR_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_flag_clr && !(cnt_tick && t1_cnt == '0)) |=> !t1_flag); // R13
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] reg_idx = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic wr_en = 0, rd_en = 0, cnt_tick = 0, t1_free_run = 0;
    logic t1_flag_clr = 0, t2_flag_clr = 0, t1_flag, t2_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .cnt_tick(cnt_tick),
        .t1_free_run(t1_free_run), .t1_flag_clr(t1_flag_clr),
        .t2_flag_clr(t2_flag_clr), .t1_flag(t1_flag), .t2_flag(t2_flag)
    );

    int n_cmp = 0, n_bad = 0;
    logic [15:0] m_cnt1, m_lat1, m_cnt2;
    logic [7:0]  m_lat2, last_rd;
    logic        m_arm1, m_arm2, m_flag1, m_flag2;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [3:0] i);
        case (i)
            4'h4: return m_cnt1[7:0];
            4'h5: return m_cnt1[15:8];
            4'h6: return m_lat1[7:0];
            4'h7: return m_lat1[15:8];
            4'h8: return m_cnt2[7:0];
            4'h9: return m_cnt2[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] i);
        if (i == 4'h4 || i == 4'h5) return "R5 read counter 1";
        if (i == 4'h6 || i == 4'h7) return "R6 read latch 1";
        if (i == 4'h8 || i == 4'h9) return "R8 read counter 2";
        return "R14 unused index read";
    endfunction

    task automatic step(input logic [3:0] i, input logic [7:0] wd, input logic we, re,
                        input logic tk, fr, c1, c2);
        logic ld1, ld2, uf1, uf2, cl1, cl2;
        logic [15:0] n_cnt1, n_lat1, n_cnt2;
        logic [7:0]  n_lat2;
        logic        n_arm1, n_arm2, n_f1, n_f2;
        @(negedge clk);
        reg_idx = i; wr_data = wd; wr_en = we; rd_en = re; cnt_tick = tk;
        t1_free_run = fr; t1_flag_clr = c1; t2_flag_clr = c2;
        #1;
        last_rd = rd_data;
        if (re) chk(rd_tag(i), {8'h00, rd_data}, {8'h00, model_rd(i)});
        ld1 = we && i == 4'h5;
        ld2 = we && i == 4'h9;
        n_lat1 = m_lat1;
        if (we && (i == 4'h4 || i == 4'h6)) n_lat1[7:0] = wd;
        if (we && (i == 4'h5 || i == 4'h7)) n_lat1[15:8] = wd;
        uf1 = tk && m_cnt1 == 16'h0 && !ld1;
        if (ld1) n_cnt1 = {wd, m_lat1[7:0]};
        else if (tk) n_cnt1 = (m_cnt1 == 16'h0) ? (fr ? m_lat1 : 16'hFFFF) : m_cnt1 - 16'h1;
        else n_cnt1 = m_cnt1;
        cl1 = (we && (i == 4'h5 || i == 4'h7)) || (re && i == 4'h4) || c1;
        n_f1 = (uf1 && m_arm1) ? 1'b1 : (cl1 ? 1'b0 : m_flag1);
        n_arm1 = ld1 ? 1'b1 : ((uf1 && !fr) ? 1'b0 : m_arm1);
        n_lat2 = (we && i == 4'h8) ? wd : m_lat2;
        uf2 = tk && m_cnt2 == 16'h0 && !ld2;
        n_cnt2 = ld2 ? {wd, m_lat2} : (tk ? m_cnt2 - 16'h1 : m_cnt2);
        cl2 = (re && i == 4'h8) || c2;
        n_f2 = (uf2 && m_arm2) ? 1'b1 : (cl2 ? 1'b0 : m_flag2);
        n_arm2 = ld2 ? 1'b1 : (uf2 ? 1'b0 : m_arm2);
        @(posedge clk);
        #1;
        m_cnt1 = n_cnt1; m_lat1 = n_lat1; m_arm1 = n_arm1; m_flag1 = n_f1;
        m_cnt2 = n_cnt2; m_lat2 = n_lat2; m_arm2 = n_arm2; m_flag2 = n_f2;
        chk("R10 R11 R13 t1_flag", {15'h0, t1_flag}, {15'h0, m_flag1});
        chk("R12 R13 t2_flag", {15'h0, t2_flag}, {15'h0, m_flag2});
    endtask

    task automatic wr(input logic [3:0] i, input logic [7:0] d, input logic fr = 0);
        step(i, d, 1, 0, 0, fr, 0, 0);
    endtask

    task automatic rd_exp(input logic [3:0] i, input logic [7:0] e, input string tag,
                          input logic fr = 0);
        step(i, 8'h00, 0, 1, 0, fr, 0, 0);
        chk(tag, {8'h00, last_rd}, {8'h00, e});
    endtask

    task automatic ticks(input int n, input logic fr = 0);
        for (int k = 0; k < n; k++) step(4'h0, 8'h00, 0, 0, 1, fr, 0, 0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic fr_r;
        void'($urandom(32'h1F2E3D4C));
        m_cnt1 = 16'hFFFF; m_lat1 = 16'h0; m_cnt2 = 16'hFFFF; m_lat2 = 8'h0;
        m_arm1 = 0; m_arm2 = 0; m_flag1 = 0; m_flag2 = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 t1_flag reset", {15'h0, t1_flag}, 16'h0);
        chk("R1 t2_flag reset", {15'h0, t2_flag}, 16'h0);
        rd_exp(4'h4, 8'hFF, "R1 counter 1 low");
        rd_exp(4'h6, 8'h00, "R1 latch 1 low");
        rd_exp(4'h9, 8'hFF, "R1 counter 2 high");
        // latch low writes, no reload
        wr(4'h6, 8'h03);
        rd_exp(4'h6, 8'h03, "R2 latch low via 0x6");
        rd_exp(4'h4, 8'hFF, "R2 no reload");
        wr(4'h4, 8'h05);
        rd_exp(4'h6, 8'h05, "R2 latch low via 0x4");
        rd_exp(4'h7, 8'h00, "R2 latch high kept");
        // load and one-shot
        wr(4'h5, 8'h00);
        rd_exp(4'h4, 8'h05, "R3 counter loaded");
        ticks(1);
        rd_exp(4'h4, 8'h04, "R9 decrement");
        rd_exp(4'h4, 8'h04, "R9 hold without tick");
        ticks(5);
        chk("R10 flag at pass through zero", {15'h0, t1_flag}, 16'h1);
        rd_exp(4'h5, 8'hFF, "R10 wrap to FFFF");
        chk("R5 high read keeps flag", {15'h0, t1_flag}, 16'h1);
        rd_exp(4'h4, 8'hFF, "R10 low after wrap");
        chk("R5 low read clears flag", {15'h0, t1_flag}, 16'h0);
        wr(4'h7, 8'h12);
        rd_exp(4'h7, 8'h12, "R4 latch high stored");
        rd_exp(4'h5, 8'hFF, "R4 no reload");
        // free-run
        wr(4'h6, 8'h02, 1);
        wr(4'h5, 8'h00, 1);
        ticks(3, 1);
        chk("R11 flag in free run", {15'h0, t1_flag}, 16'h1);
        rd_exp(4'h4, 8'h02, "R11 reload from latch", 1);
        ticks(3, 1);
        chk("R11 flag again", {15'h0, t1_flag}, 16'h1);
        wr(4'h7, 8'h00, 1);
        chk("R4 write clears flag", {15'h0, t1_flag}, 16'h0);
        // collisions: counter 1 now 0x0002
        ticks(2, 1);
        step(4'h0, 8'h00, 0, 0, 1, 1, 1, 0);
        chk("R13 set beats clear", {15'h0, t1_flag}, 16'h1);
        step(4'h0, 8'h00, 0, 0, 0, 1, 1, 0);
        chk("R13 clear input", {15'h0, t1_flag}, 16'h0);
        ticks(2, 1);
        step(4'h5, 8'h00, 1, 0, 1, 1, 0, 0);
        rd_exp(4'h4, 8'h02, "R13 load beats tick", 1);
        chk("R13 load cancels flag", {15'h0, t1_flag}, 16'h0);
        // timer 2
        wr(4'h8, 8'h03);
        wr(4'h9, 8'h00);
        rd_exp(4'h8, 8'h03, "R7 counter 2 loaded");
        ticks(4);
        chk("R12 timer 2 flag", {15'h0, t2_flag}, 16'h1);
        rd_exp(4'h9, 8'hFF, "R8 high after wrap");
        chk("R8 high read keeps flag", {15'h0, t2_flag}, 16'h1);
        rd_exp(4'h8, 8'hFF, "R8 low read");
        chk("R8 low read clears flag", {15'h0, t2_flag}, 16'h0);
        ticks(65540);
        chk("R12 no second flag", {15'h0, t2_flag}, 16'h0);
        // unused index
        wr(4'hC, 8'h55);
        rd_exp(4'hC, 8'h00, "R14 unused read zero");
        rd_exp(4'h6, 8'h02, "R14 latch untouched");
        // random phase
        fr_r = 0;
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] i;
            logic [7:0] d;
            int r;
            if (n % 500 == 0) fr_r = $urandom % 2;
            i = 4'($urandom % 16);
            d = 8'($urandom);
            if ((i == 4'h5 || i == 4'h9) && ($urandom % 4 != 0)) d = 8'h00;
            if ((i == 4'h4 || i == 4'h6 || i == 4'h8) && ($urandom % 2 == 0)) d = d % 8;
            r = $urandom % 3;
            step(i, d, r == 0, r == 1, ($urandom % 4) != 0, fr_r,
                 ($urandom % 16) == 0, ($urandom % 16) == 0);
        end
        step(4'h0, 8'h00, 0, 0, 0, 0, 0, 0);
        summary();
        $finish;
    end
endmodule